// File: doc/BRIEF.md
# Bus-Master DMA Channel Engine

This block is one channel of a storage controller's bus-master DMA function. Software sees an 8-byte register window: a command register, a status register and a 32-bit pointer to a table of transfer descriptors in system memory. When the command register is written with the start bit and the device-to-memory direction, the engine reads descriptors one at a time through a memory read port. For each descriptor it copies words from the drive-side data stream to system memory through a memory write port. It stops after the descriptor flagged as the last one. At that point it raises the channel interrupt and reports a completed command to the task-file status logic.

The register port is a single-cycle access: the host holds `cfg_valid` with offset, length and data, and `cfg_rdata` and `cfg_rej` are valid in the same cycle. A rejected access changes no state.

Every data path uses valid/ready. A request is transferred on a clock edge where both valid and ready are high. Once the engine raises `dr_valid` or `wr_valid`, it holds the address and data until ready is seen. `dr_rvalid` is a single-cycle response pulse and cannot be back-pressured. The source stream is passed straight to the write port. As a result `src_ready` is high exactly when a memory write is accepted, and a source word is consumed only on that same edge.

Top module: `ide_bm_channel`

## Requirements
- R1: The register offsets are fixed: 0 is command (bit 0 start, bit 3 direction, 1 = device-to-memory), 2 is status (bit 0 active, bit 1 error, bit 2 interrupt) and 4 to 7 are pointer bytes 0 to 3. Any access to offset 1 or 3 is rejected. After reset, command, status and pointer all read 0.
- R2: A pointer access at offset 4+k with length n (1 to 4 bytes) uses data byte i for pointer byte k+i. An access with n = 0 or k+n > 4 is rejected and changes no pointer byte.
- R3: A status access whose length is not exactly 1 is rejected and has no effect.
- R4: A command write with start = 1 while status is idle sets the active bit. A command write with start = 0 while idle resets the table index to 0. Each descriptor is fetched from pointer + 8 × index.
- R5: Each descriptor is 64 bits. Bits 31:0 hold the buffer base, bits 47:32 the byte count (bits 33:32 ignored) and bit 63 the end flag. The words of each entry go to base, base+4, … in source order, and entries are handled in table order until the flagged one completes.
- R6: On completion, active clears and interrupt sets. `tf_set` pulses once with `tf_status` = 0x50 (busy 0, ready 1, DRQ 0, error 0, seek complete 1).
- R7: `irq` is high exactly when the interrupt bit is set and `irq_disable` is low.
- R8: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0, or writing the active bit, has no effect. A completion in the same cycle as the clear wins.
- R9: If `wr_err` is high on an accepted write, the transfer ends at once with error and interrupt set and no further memory access.
- R10: A start with direction 0 makes no memory access and completes on the next cycle with error and interrupt set.
- R11: While `dr_valid` or `wr_valid` waits for ready, its address and data stay stable.
- R12: A start that is not preceded by a start = 0 write continues at the index after the last completed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_valid | input | 1 | Register access this cycle |
| cfg_write | input | 1 | 1 write, 0 read |
| cfg_off | input | 3 | Register offset in the window |
| cfg_len | input | 3 | Access length in bytes |
| cfg_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| cfg_rdata | output | 32 | Read data for the current access |
| cfg_rej | output | 1 | Current access is rejected |
| irq_disable | input | 1 | Interrupt-disable bit of the control register |
| irq | output | 1 | Channel interrupt |
| tf_set | output | 1 | Completion pulse to task-file status |
| tf_status | output | 8 | Task-file status value to load |
| dr_valid | output | 1 | Descriptor read request |
| dr_ready | input | 1 | Descriptor request accepted |
| dr_addr | output | 32 | Descriptor address |
| dr_rvalid | input | 1 | Descriptor data pulse |
| dr_rdata | input | 64 | Descriptor data |
| src_valid | input | 1 | Source word available |
| src_ready | output | 1 | Source word consumed |
| src_data | input | 32 | Source word |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_err | input | 1 | Accepted write failed |

## Verification
Two events can fall on the same edge: a completion that sets the interrupt and error bits, and a host write-one-to-clear of those bits. The bench provokes this deterministically. With the interrupt bit already set, it issues a direction-0 start; that start completes on the next edge, and the bench issues the clearing status write for that exact edge. Both bits must then read as set. A second clear one cycle later must empty them. Transfers run under several ready patterns so that back-pressure, zero-length entries and an injected write failure each meet the completion path.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
  localparam logic [2:0] OFF_CMD  = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd2;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int ST_ERR_BIT    = 1;
  localparam int ST_INT_BIT    = 2;
  localparam int PTR_BYTES     = 4;
  localparam logic [7:0] TF_DONE_VAL = 8'h50;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_FETCH, ENG_WAIT, ENG_MOVE, ENG_DONE
  } eng_state_e;

  typedef struct packed {
    logic        last;
    logic [14:0] unused;
    logic [15:0] nbytes;
    logic [31:0] base;
  } bm_desc_t;
endpackage

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic        cfg_write,
  input  logic [2:0]  cfg_off,
  input  logic [2:0]  cfg_len,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_rej,
  input  logic        done,
  input  logic        fail,
  output logic        go,
  output logic        idx_clr,
  output logic        go_dir,
  output logic [31:0] ptr,
  output logic        int_flag
);
  logic [31:0] ptr_q;
  logic        active_q, err_q, int_q, cmd_start_q, cmd_dir_q;
  logic [1:0]  lane;
  logic        in_ptr, ptr_bad, acc, wr, cmd_wr, stat_wr;
  logic [3:0]  span;
  logic [31:0] wshift, rshift;

  assign lane    = cfg_off[1:0];
  assign in_ptr  = cfg_off[2];
  assign span    = {1'b0, cfg_len} + {2'b00, lane};
  assign ptr_bad = (cfg_len == 3'd0) || (span > 4'd4);

  always_comb begin
    cfg_rej = cfg_valid && ((cfg_off == 3'd1) || (cfg_off == 3'd3) ||
              ((cfg_off == OFF_STAT) && (cfg_len != 3'd1)) || (in_ptr && ptr_bad));
  end

  assign acc     = cfg_valid && !cfg_rej;
  assign wr      = acc && cfg_write;
  assign cmd_wr  = wr && (cfg_off == OFF_CMD);
  assign stat_wr = wr && (cfg_off == OFF_STAT);
  assign go      = cmd_wr && cfg_wdata[CMD_START_BIT] && !active_q;
  assign idx_clr = cmd_wr && !cfg_wdata[CMD_START_BIT] && !active_q;
  assign go_dir  = cfg_wdata[CMD_DIR_BIT];
  assign ptr     = ptr_q;
  assign int_flag = int_q;

  assign wshift = cfg_wdata << {lane, 3'b000};
  assign rshift = ptr_q >> {lane, 3'b000};

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_ptr_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[8*b +: 8] <= 8'h00;
      else if (wr && in_ptr && (3'(b) >= {1'b0, lane}) && (4'(b) < span))
        ptr_q[8*b +: 8] <= wshift[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      err_q       <= 1'b0;
      int_q       <= 1'b0;
      cmd_start_q <= 1'b0;
      cmd_dir_q   <= 1'b0;
    end else begin
      if (cmd_wr) begin
        cmd_start_q <= cfg_wdata[CMD_START_BIT];
        cmd_dir_q   <= cfg_wdata[CMD_DIR_BIT];
      end
      if (done)    active_q <= 1'b0;
      else if (go) active_q <= 1'b1;
      err_q <= (err_q & ~(stat_wr & cfg_wdata[ST_ERR_BIT])) | (done & fail);
      int_q <= (int_q & ~(stat_wr & cfg_wdata[ST_INT_BIT])) | done;
    end
  end

  always_comb begin
    cfg_rdata = 32'h0;
    if (acc) begin
      if (cfg_off == OFF_CMD) begin
        cfg_rdata[CMD_START_BIT] = cmd_start_q;
        cfg_rdata[CMD_DIR_BIT]   = cmd_dir_q;
      end else if (cfg_off == OFF_STAT) begin
        cfg_rdata[2:0] = {int_q, err_q, active_q};
      end else if (in_ptr) begin
        for (int i = 0; i < PTR_BYTES; i++)
          if (3'(i) < cfg_len) cfg_rdata[8*i +: 8] = rshift[8*i +: 8];
      end
    end
  end

  assert_rej_keeps_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_write && cfg_rej |=> $stable(ptr_q));
  assert_go_sets_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> active_q);
  assert_done_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active_q && int_q);
  assert_fail_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |=> err_q);
endmodule

// File: rtl/ide_bm_engine.sv
module ide_bm_engine
  import ide_bm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 16,
  parameter int CNTW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_dir,
  input  logic          idx_clr,
  input  logic [AW-1:0] ptr,
  output logic          dr_valid,
  input  logic          dr_ready,
  output logic [AW-1:0] dr_addr,
  input  logic          dr_rvalid,
  input  logic [63:0]   dr_rdata,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [31:0]   src_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_err,
  output logic          done,
  output logic          fail
);
  localparam int WW = CNTW - 2;

  eng_state_e      state_q;
  logic [IDXW-1:0] idx_q;
  logic [AW-1:0]   addr_q;
  logic [WW-1:0]   left_q;
  logic            last_q, fail_q;
  bm_desc_t        desc;
  logic            wr_fire;

  assign desc      = bm_desc_t'(dr_rdata);
  assign dr_valid  = (state_q == ENG_FETCH);
  assign dr_addr   = ptr + (AW'(idx_q) << 3);
  assign wr_valid  = (state_q == ENG_MOVE) && src_valid;
  assign src_ready = (state_q == ENG_MOVE) && wr_ready;
  assign wr_addr   = addr_q;
  assign wr_data   = src_data;
  assign wr_fire   = wr_valid && wr_ready;
  assign done      = (state_q == ENG_DONE);
  assign fail      = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (idx_clr) idx_q <= '0;
          if (go) begin
            fail_q  <= !go_dir;
            state_q <= go_dir ? ENG_FETCH : ENG_DONE;
          end
        end
        ENG_FETCH: if (dr_ready) state_q <= ENG_WAIT;
        ENG_WAIT: if (dr_rvalid) begin
          addr_q <= AW'(desc.base);
          left_q <= desc.nbytes[CNTW-1:2];
          last_q <= desc.last;
          if (desc.nbytes[CNTW-1:2] == '0) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= desc.last ? ENG_DONE : ENG_FETCH;
          end else begin
            state_q <= ENG_MOVE;
          end
        end
        ENG_MOVE: if (wr_fire) begin
          if (wr_err) begin
            fail_q  <= 1'b1;
            state_q <= ENG_DONE;
          end else begin
            addr_q <= addr_q + AW'(4);
            left_q <= left_q - 1'b1;
            if (left_q == WW'(1)) begin
              idx_q   <= idx_q + 1'b1;
              state_q <= last_q ? ENG_DONE : ENG_FETCH;
            end
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assert_dr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr));
  assert_wr_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable(wr_addr));
  assert_dir0_fails_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go && !go_dir |=> done && fail);
  assert_err_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && wr_err |=> done && !wr_valid);
endmodule

// File: rtl/ide_bm_channel.sv
module ide_bm_channel
  import ide_bm_pkg::*;
#(
  parameter int IDXW = 16,
  parameter int CNTW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic        cfg_write,
  input  logic [2:0]  cfg_off,
  input  logic [2:0]  cfg_len,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_rej,
  input  logic        irq_disable,
  output logic        irq,
  output logic        tf_set,
  output logic [7:0]  tf_status,
  output logic        dr_valid,
  input  logic        dr_ready,
  output logic [31:0] dr_addr,
  input  logic        dr_rvalid,
  input  logic [63:0] dr_rdata,
  input  logic        src_valid,
  output logic        src_ready,
  input  logic [31:0] src_data,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  input  logic        wr_err
);
  logic        go, idx_clr, go_dir, done, fail, int_flag;
  logic [31:0] ptr;

  ide_bm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_off(cfg_off), .cfg_len(cfg_len), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rej(cfg_rej), .done(done), .fail(fail),
    .go(go), .idx_clr(idx_clr), .go_dir(go_dir), .ptr(ptr), .int_flag(int_flag)
  );

  ide_bm_engine #(.AW(32), .IDXW(IDXW), .CNTW(CNTW)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .go_dir(go_dir), .idx_clr(idx_clr),
    .ptr(ptr), .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_rvalid(dr_rvalid), .dr_rdata(dr_rdata), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
    .done(done), .fail(fail)
  );

  assign irq       = int_flag && !irq_disable;
  assign tf_set    = done;
  assign tf_status = TF_DONE_VAL;
endmodule

// File: tb/tb_ide_bm_channel.sv
`timescale 1ns/1ps
module tb_ide_bm_channel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 0, cfg_write = 0;
  logic [2:0] cfg_off = 0, cfg_len = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic cfg_rej, irq_disable = 0, irq, tf_set;
  logic [7:0] tf_status;
  logic dr_valid, dr_ready = 0, dr_rvalid = 0;
  logic [31:0] dr_addr;
  logic [63:0] dr_rdata = 0;
  logic src_valid = 1, src_ready, wr_valid, wr_ready = 0, wr_err = 0;
  logic [31:0] src_data = 0, wr_addr, wr_data;

  ide_bm_channel dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, mode = 0, fail_at = -1;
  logic [31:0] d_base [8];
  int          d_bytes[8];
  logic        d_last [8];
  logic [31:0] tbl = 0;
  logic [31:0] wl_addr[64], wl_data[64], fl_addr[64];
  int wl_n = 0, fl_n = 0, tf_cnt = 0;
  logic [7:0] tf_last = 0;
  logic pend = 0, consumed = 0;
  int pend_idx = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory and stream responder
  initial forever begin
    @(negedge clk);
    cyc++;
    dr_rvalid = 1'b0;
    if (pend) begin
      dr_rvalid = 1'b1;
      dr_rdata  = {d_last[pend_idx], 15'h0, 16'(d_bytes[pend_idx]), d_base[pend_idx]};
      pend = 0;
    end
    if (consumed) begin src_data = src_data + 1; consumed = 0; end
    case (mode)
      0: begin dr_ready = 1; wr_ready = 1; end
      1: begin dr_ready = (cyc % 3) != 0; wr_ready = (cyc % 3) != 1; end
      2: begin dr_ready = (cyc % 2) == 1; wr_ready = (cyc % 2) == 0; end
      default: begin dr_ready = 0; wr_ready = 0; end
    endcase
    wr_err = (wl_n == fail_at);
    if (dr_valid && dr_ready) begin
      pend = 1;
      pend_idx = int'((dr_addr - tbl) >> 3) & 7;
      if (fl_n < 64) fl_addr[fl_n] = dr_addr;
      fl_n++;
    end
    if (wr_valid && wr_ready) begin
      if (wl_n < 64) begin wl_addr[wl_n] = wr_addr; wl_data[wl_n] = wr_data; end
      wl_n++;
      consumed = 1;
    end
    if (tf_set) begin tf_cnt++; tf_last = tf_status; end
  end

  task automatic cfg(input logic w, input logic [2:0] off, input logic [2:0] len,
                     input logic [31:0] d, output logic [31:0] rd, output logic rj);
    cfg_valid = 1; cfg_write = w; cfg_off = off; cfg_len = len; cfg_wdata = d;
    #1;
    rd = cfg_rdata; rj = cfg_rej;
    @(negedge clk);
    cfg_valid = 0; cfg_write = 0;
  endtask

  task automatic wreg(input logic [2:0] off, input logic [2:0] len, input logic [31:0] d);
    logic [31:0] rd; logic rj;
    cfg(1'b1, off, len, d, rd, rj);
  endtask

  function automatic logic [31:0] rreg_f(input logic [31:0] v); return v; endfunction

  task automatic rstat(output logic [2:0] s);
    logic [31:0] rd; logic rj;
    cfg(1'b0, 3'd2, 3'd1, 32'h0, rd, rj);
    s = rd[2:0];
  endtask

  task automatic wait_tf(input int n);
    for (int i = 0; i < 3000 && tf_cnt < n; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input int nd, input int md, input int zero_at, input logic [31:0] t);
    for (int i = 0; i < 8; i++) begin
      d_base[i]  = 32'h1000_0000 + 32'(i) * 32'h100 + 32'(md) * 32'h1_0000;
      d_bytes[i] = 4 * (((i + md) % 4) + 1);
      d_last[i]  = (i == nd - 1);
    end
    if (zero_at >= 0) d_bytes[zero_at] = 3;
    tbl = t;
  endtask

  task automatic run_xfer(input int nd, input int md, input int zero_at, input int fpos, input logic [31:0] t);
    logic [2:0] s; int exp_n, t0; logic ok; logic [31:0] sbase;
    setup(nd, md, zero_at, t);
    mode = md; fail_at = fpos;
    wreg(3'd4, 3'd4, t);
    wreg(3'd0, 3'd1, 32'h0);
    wl_n = 0; fl_n = 0; t0 = tf_cnt;
    sbase = 32'hA000_0000 + 32'(md) * 32'h100 + 32'(nd);
    src_data = sbase;
    wreg(3'd0, 3'd1, 32'h9);
    wait_tf(t0 + 1);
    exp_n = 0; ok = 1;
    for (int i = 0; i < nd; i++)
      for (int j = 0; j < d_bytes[i] / 4; j++) begin
        if (fpos < 0 || exp_n <= fpos)
          if (exp_n < wl_n && (wl_addr[exp_n] != d_base[i] + 32'(4*j) || wl_data[exp_n] != sbase + 32'(exp_n)))
            ok = 0;
        exp_n++;
      end
    if (fpos >= 0 && fpos < exp_n) exp_n = fpos + 1;
    chk(wl_n == exp_n, "R5 write count", 32'(wl_n), 32'(exp_n));
    chk(ok, "R5 write address/data order", 32'(ok), 32'h1);
    if (fpos < 0) begin
      ok = (fl_n == nd);
      for (int i = 0; i < nd && i < fl_n; i++) if (fl_addr[i] != t + 32'(8*i)) ok = 0;
      chk(ok, "R4 descriptor fetch addresses", 32'(fl_n), 32'(nd));
    end
    chk(tf_cnt == t0 + 1 && tf_last == 8'h50, "R6 task-file update", {24'h0, tf_last}, 32'h50);
    rstat(s);
    chk(s == (fpos >= 0 ? 3'b110 : 3'b100), "R6 status after completion", 32'(s), fpos >= 0 ? 32'h6 : 32'h4);
    mode = 0; fail_at = -1;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, p, e; logic rj; logic [2:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    cfg(0, 3'd0, 3'd1, 0, rd, rj); chk(rd == 0 && !rj, "R1 reset command", rd, 0);
    rstat(s); chk(s == 0, "R1 reset status", 32'(s), 0);
    cfg(0, 3'd4, 3'd4, 0, rd, rj); chk(rd == 0, "R1 reset pointer", rd, 0);
    chk(!irq && !dr_valid && !wr_valid, "R7 reset outputs quiet", {irq, dr_valid, wr_valid}, 0);
    // invalid offsets
    for (int o = 1; o <= 3; o += 2) begin
      cfg(1, 3'(o), 3'd1, 32'hFF, rd, rj); chk(rj, "R1 offset write rejected", 32'(rj), 1);
      cfg(0, 3'(o), 3'd1, 0, rd, rj); chk(rj, "R1 offset read rejected", 32'(rj), 1);
    end
    // pointer lane sweep
    for (int k = 0; k < 4; k++)
      for (int n = 0; n <= 4; n++) begin
        p = 32'h1122_3344;
        wreg(3'd4, 3'd4, p);
        rd = 32'hA5B6C7D8 ^ 32'(k * 7 + n);
        cfg(1, 3'(4 + k), 3'(n), rd, e, rj);
        chk(rj == (n == 0 || k + n > 4), "R2 lane write rejection", 32'(rj), 32'(n == 0 || k + n > 4));
        e = p;
        if (!(n == 0 || k + n > 4))
          for (int i = 0; i < n; i++) e[8*(k+i) +: 8] = rd[8*i +: 8];
        cfg(0, 3'd4, 3'd4, 0, p, rj);
        chk(p == e, "R2 pointer after lane write", p, e);
        if (!(n == 0 || k + n > 4)) begin
          cfg(0, 3'(4 + k), 3'(n), 0, p, rj);
          e = 0;
          for (int i = 0; i < n; i++) e[8*i +: 8] = rd[8*i +: 8];
          chk(p == e && !rj, "R2 lane read", p, e);
        end
      end
    // transfers under back-pressure
    run_xfer(3, 0, -1, -1, 32'h0000_2000);
    chk(irq, "R7 irq after completion", 32'(irq), 1);
    irq_disable = 1; #1;
    chk(!irq, "R7 irq masked by disable", 32'(irq), 0);
    irq_disable = 0; #1;
    chk(irq, "R7 irq returns when enabled", 32'(irq), 1);
    wreg(3'd2, 3'd1, 32'h1);
    rstat(s); chk(s == 3'b100, "R8 active bit write ignored", 32'(s), 4);
    cfg(1, 3'd2, 3'd2, 32'h4, rd, rj);
    chk(rj, "R3 wide status write rejected", 32'(rj), 1);
    cfg(0, 3'd2, 3'd4, 0, rd, rj);
    chk(rj, "R3 wide status read rejected", 32'(rj), 1);
    rstat(s); chk(s == 3'b100, "R3 rejected status write no effect", 32'(s), 4);
    wreg(3'd2, 3'd1, 32'h4);
    rstat(s); chk(s == 0 && !irq, "R8 interrupt cleared", 32'(s), 0);
    run_xfer(4, 1, 1, -1, 32'h0000_3000);
    wreg(3'd2, 3'd1, 32'h6);
    run_xfer(1, 2, -1, -1, 32'h0000_4008);
    wreg(3'd2, 3'd1, 32'h6);
    run_xfer(8, 1, -1, -1, 32'h0001_0000);
    wreg(3'd2, 3'd1, 32'h6);
    // active while waiting, then restart continuation
    setup(2, 0, -1, 32'h0000_5000);
    d_last[2] = 1; d_last[0] = 0;
    wreg(3'd4, 3'd4, tbl);
    wreg(3'd0, 3'd1, 32'h0);
    mode = 3; fl_n = 0;
    wreg(3'd0, 3'd1, 32'h9);
    rstat(s); chk(s == 3'b001, "R4 active while running", 32'(s), 1);
    cfg(0, 3'd0, 3'd1, 0, rd, rj); chk(rd == 32'h9, "R1 command readback", rd, 9);
    mode = 0;
    wait_tf(tf_cnt + 1);
    wreg(3'd2, 3'd1, 32'h6);
    fl_n = 0;
    wreg(3'd0, 3'd1, 32'h9);
    wait_tf(tf_cnt + 1);
    chk(fl_n == 1 && fl_addr[0] == tbl + 32'd16, "R12 restart continues at index", fl_addr[0], tbl + 16);
    wreg(3'd2, 3'd1, 32'h6);
    fl_n = 0;
    wreg(3'd0, 3'd1, 32'h0);
    wreg(3'd0, 3'd1, 32'h9);
    wait_tf(tf_cnt + 2);
    chk(fl_n >= 1 && fl_addr[0] == tbl, "R4 start=0 resets index", fl_addr[0], tbl);
    wreg(3'd2, 3'd1, 32'h6);
    // write failure
    run_xfer(2, 1, -1, 2, 32'h0000_6000);
    chk(irq, "R9 irq after failed write", 32'(irq), 1);
    wreg(3'd2, 3'd1, 32'h6);
    // direction 0
    fl_n = 0; wl_n = 0;
    wreg(3'd0, 3'd1, 32'h1);
    @(negedge clk);
    rstat(s);
    chk(s == 3'b110 && fl_n == 0 && wl_n == 0, "R10 direction 0 fails without access", 32'(s), 6);
    // same-cycle completion vs clear
    wreg(3'd2, 3'd1, 32'h2);
    rstat(s); chk(s == 3'b100, "R8 error cleared alone", 32'(s), 4);
    wreg(3'd0, 3'd1, 32'h1);
    wreg(3'd2, 3'd1, 32'h6);
    rstat(s); chk(s == 3'b110, "R8 completion wins over clear", 32'(s), 6);
    wreg(3'd2, 3'd1, 32'h0);
    rstat(s); chk(s == 3'b110, "R8 zero write no effect", 32'(s), 6);
    wreg(3'd2, 3'd1, 32'h6);
    rstat(s); chk(s == 0, "R8 later clear empties bits", 32'(s), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule